// File: doc/BRIEF.md
# Random Number Generator Register Interface

This block is a small memory-mapped random byte source. It has three byte-wide registers: control/status, data and mode. They sit in a 4 KiB window on a simple strobe bus, with address, write strobe, write data, read strobe and registered read data. To use it, software first sets the mode register to the normal value and sets the enable bit. It then polls the control/status register until the data-valid flag is set, and reads one byte from the data register. That read consumes the flag.

The byte comes from an internal stand-in entropy source: a 16-bit maximal-length LFSR that steps on every clock. The source offers its low byte together with a valid indication. A byte is captured lazily, only when status is polled while the generator is active and no byte is pending.

The control/status register also holds a 4-bit clock prescaler field. Software can store it and read it back, but it does not affect generation. Illegal accesses change no state and raise a one-cycle error pulse.

Top module: `rng_regif`

## Requirements
- R1: After reset, all three registers read zero, rdata_o is 0x00 and err_o is 0. The generator is therefore disabled and the valid flag is clear.
- R2: A write to control/status (offset 0x00) stores every written bit except bit 1. Bit 1, the valid flag, keeps its previous value. Bits 5:2 (prescaler) and bit 0 (enable) read back as written.
- R3: The generator is active only when control/status bit 0 is 1 and the mode register (offset 0x08, readable and writable) holds exactly 0x02. With any other mode value it is inactive.
- R4: A read of control/status while inactive clears the valid flag. The returned value shows the flag as clear.
- R5: A read of control/status while active with the flag clear latches the source's low byte into the data register and sets the flag. The read returns the updated status. A status read while active with the flag already set captures nothing.
- R6: A read of the data register (offset 0x04) while active with the flag set returns the latched byte and clears the flag.
- R7: A data register read while inactive, or while the flag is clear, returns the last latched byte and leaves the flag unchanged.
- R8: Writes to the data register are discarded and give err_o=1 in the cycle after the strobe.
- R9: Any offset other than 0x00, 0x04 and 0x08 is undecoded. A read of it returns 0x00, a write to it is discarded, and either gives err_o=1 in the cycle after the strobe.
- R10: The source state resets to 0xACE1. On each clock it shifts right by one, and the new bit 15 is the XOR of bits 0, 2, 3 and 5. The captured byte is state bits 7:0 at the capturing edge.
- R11: Read data appears on rdata_o in the cycle after the read strobe. In every cycle that follows no performed read, rdata_o is 0x00.
- R12: When wr_en_i and rd_en_i are high together, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (12) | Byte offset within the window |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| err_o | output | 1 | Illegal-access pulse |

## Verification
Every result, whether read data, error pulse or register update, is due exactly one clock after the edge that samples the strobe. The bench drives a strobe on a falling edge, lets one rising edge pass, and then samples rdata_o and err_o on the next falling edge. The bench steps its own LFSR model on the same rising edges as the design. It takes the model value at the moment it drives a strobe, so the expected captured byte is the state at the capturing edge. An idle cycle always separates two operations, and the bench also checks that rdata_o returns to zero in those cycles.

// File: rtl/rng_regif_pkg.sv
package rng_regif_pkg;
  parameter int unsigned OFF_CTRL = 'h00;
  parameter int unsigned OFF_DATA = 'h04;
  parameter int unsigned OFF_MODE = 'h08;
  parameter int unsigned EN_BIT   = 0;
  parameter int unsigned VLD_BIT  = 1;
  parameter logic [7:0]  MODE_RUN = 8'h02;
  parameter logic [7:0]  VLD_MASK = 8'h02;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int unsigned           W     = 16,
  parameter logic [W-1:0]          SEED  = 16'hACE1,
  parameter logic [W-1:0]          TAPS  = 16'h002D,
  parameter int unsigned           OUT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] byte_o,
  output logic             vld_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {fb, state_q[W-1:1]};
  end

  assign byte_o = state_q[OUT_W-1:0];
  assign vld_o  = |state_q;
endmodule

// File: rtl/rng_addr_decode.sv
module rng_addr_decode
  import rng_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sel_ctrl_o,
  output logic              sel_data_o,
  output logic              sel_mode_o
);
  assign sel_ctrl_o = (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_data_o = (addr_i == ADDR_W'(OFF_DATA));
  assign sel_mode_o = (addr_i == ADDR_W'(OFF_MODE));
endmodule

// File: rtl/rng_regif.sv
module rng_regif
  import rng_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS = 16'h002D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_en_i,
  output logic [7:0]        rdata_o,
  output logic              err_o
);
  logic [7:0] ctrl_q, ctrl_d, data_q, data_d, mode_q, mode_d, rdata_d;
  logic       err_d, active, rd_go;
  logic       sel_ctrl, sel_data, sel_mode;
  logic [7:0] src_byte;
  logic       src_vld;

  rng_lfsr #(.W(LFSR_W), .SEED(SEED), .TAPS(TAPS), .OUT_W(8)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .byte_o (src_byte),
    .vld_o  (src_vld)
  );

  rng_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i     (addr_i),
    .sel_ctrl_o (sel_ctrl),
    .sel_data_o (sel_data),
    .sel_mode_o (sel_mode)
  );

  assign active = ctrl_q[EN_BIT] && (mode_q == MODE_RUN);
  assign rd_go  = rd_en_i && !wr_en_i;  // write wins

  always_comb begin
    ctrl_d  = ctrl_q;
    data_d  = data_q;
    mode_d  = mode_q;
    rdata_d = '0;
    err_d   = 1'b0;
    if (wr_en_i) begin
      if (sel_ctrl)      ctrl_d = (wdata_i & ~VLD_MASK) | (ctrl_q & VLD_MASK);
      else if (sel_mode) mode_d = wdata_i;
      else               err_d  = 1'b1;
    end else if (rd_go) begin
      if (sel_ctrl) begin
        if (!active) begin
          ctrl_d[VLD_BIT] = 1'b0;
        end else if (!ctrl_q[VLD_BIT] && src_vld) begin
          data_d          = src_byte;
          ctrl_d[VLD_BIT] = 1'b1;
        end
        rdata_d = ctrl_d;
      end else if (sel_data) begin
        rdata_d = data_q;
        if (active && ctrl_q[VLD_BIT]) ctrl_d[VLD_BIT] = 1'b0;
      end else if (sel_mode) begin
        rdata_d = mode_q;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      data_q  <= '0;
      mode_q  <= '0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      data_q  <= data_d;
      mode_q  <= mode_d;
      rdata_o <= rdata_d;
      err_o   <= err_d;
    end
  end
endmodule

// File: rtl/rng_regif_chk.sv
module rng_regif_chk
  import rng_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [7:0]        rdata_o,
  input logic              err_o,
  input logic [7:0]        ctrl_q,
  input logic [7:0]        data_q,
  input logic              active,
  input logic              src_vld
);
  assert_vld_not_writable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_CTRL)) |=> ctrl_q[VLD_BIT] == $past(ctrl_q[VLD_BIT]));

  assert_vld_rise_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_q[VLD_BIT]) |-> $past(active && rd_en_i && !wr_en_i));

  assert_data_read_consumes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == ADDR_W'(OFF_DATA) && active && ctrl_q[VLD_BIT])
      |=> !ctrl_q[VLD_BIT]);

  assert_data_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_DATA)) |=> $stable(data_q));

  assert_err_after_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_en_i || rd_en_i));

  assert_src_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_vld);

  assert_idle_rdata_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i || wr_en_i) |=> rdata_o == 8'h00);
endmodule

bind rng_regif rng_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .rdata_o (rdata_o),
  .err_o   (err_o),
  .ctrl_q  (ctrl_q),
  .data_q  (data_q),
  .active  (active),
  .src_vld (src_vld)
);

// File: tb/tb_rng_regif.sv
`timescale 1ns/1ps
module tb_rng_regif;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        err_o;

  int unsigned total = 0, bad = 0;
  bit          done = 1'b0;

  logic [7:0]  ctrl_m = '0, data_m = '0, mode_m = '0;
  logic [15:0] lfsr_m;

  always #5 clk_i = ~clk_i;

  rng_regif dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o), .err_o(err_o)
  );

  // R10 model: shift right, new msb = b0^b2^b3^b5
  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_m <= 16'hACE1;
    else         lfsr_m <= step(lfsr_m);
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic op(input bit w, input bit r, input logic [11:0] a, input logic [7:0] wd);
    logic [7:0] exp_rd;
    bit         exp_err;
    bit         act_m;
    string      tag;
    exp_rd = 8'h00; exp_err = 1'b0; tag = "R11";
    @(negedge clk_i);
    wr_en_i = w; rd_en_i = r; addr_i = a; wdata_i = wd;
    act_m = ctrl_m[0] && (mode_m == 8'h02);
    if (w) begin
      if (a == 12'h000)      begin ctrl_m = (wd & 8'hFD) | (ctrl_m & 8'h02); tag = r ? "R12 R2" : "R2"; end
      else if (a == 12'h008) begin mode_m = wd; tag = r ? "R12 R3" : "R3"; end
      else if (a == 12'h004) begin exp_err = 1'b1; tag = "R8"; end
      else                   begin exp_err = 1'b1; tag = "R9"; end
    end else if (r) begin
      if (a == 12'h000) begin
        if (!act_m) begin ctrl_m[1] = 1'b0; tag = "R4"; end
        else if (!ctrl_m[1]) begin data_m = lfsr_m[7:0]; ctrl_m[1] = 1'b1; tag = "R5 R10"; end
        else tag = "R5";
        exp_rd = ctrl_m;
      end else if (a == 12'h004) begin
        exp_rd = data_m;
        if (act_m && ctrl_m[1]) begin ctrl_m[1] = 1'b0; tag = "R6"; end
        else tag = "R7";
      end else if (a == 12'h008) begin
        exp_rd = mode_m; tag = "R3";
      end else begin
        exp_err = 1'b1; tag = "R9";
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    chk({tag, " rdata"}, rdata_o, exp_rd);
    chk({tag, " err"}, {7'b0, err_o}, {7'b0, exp_err});
  endtask

  initial begin
    #(10 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk("R1 rdata", rdata_o, 8'h00);
    chk("R1 err", {7'b0, err_o}, 8'h00);
    rst_ni = 1'b1;
    op(0, 1, 12'h000, 0);         // R1 status zero, R4
    op(0, 1, 12'h008, 0);         // R1 mode zero
    op(0, 1, 12'h004, 0);         // R1 data zero, R7
    op(1, 0, 12'h000, 8'h3F);     // R2 valid bit masked
    op(0, 1, 12'h000, 0);         // R3 mode 0 -> inactive
    op(1, 0, 12'h008, 8'h03);     // R3 near miss
    op(0, 1, 12'h000, 0);
    op(1, 0, 12'h008, 8'h02);
    op(0, 1, 12'h004, 0);         // R7 valid clear
    op(0, 1, 12'h000, 0);         // R5 capture
    op(0, 1, 12'h000, 0);         // R5 no recapture
    op(1, 0, 12'h004, 8'hAA);     // R8
    op(0, 1, 12'h004, 0);         // R6
    op(0, 1, 12'h004, 0);         // R7
    op(0, 1, 12'h000, 0);
    op(1, 0, 12'h000, 8'h00);     // R2 keeps valid
    op(0, 1, 12'h000, 0);         // R4 clears while inactive
    op(0, 1, 12'hFFC, 0);         // R9
    op(1, 0, 12'h00C, 8'h55);     // R9
    op(1, 1, 12'h000, 8'h15);     // R12
    op(1, 0, 12'h008, 8'h02);
    op(0, 0, 12'h000, 0);         // R11 idle
    for (int i = 0; i < 600; i++) begin
      int unsigned k;
      logic [11:0] a;
      logic [7:0]  wd;
      bit          w, r;
      k = $urandom_range(0, 9);
      a = (k < 4) ? 12'h000 : (k < 7) ? 12'h004 : (k < 9) ? 12'h008 : 12'($urandom);
      wd = 8'($urandom);
      if (a == 12'h008 && $urandom_range(0, 2) != 0) wd = 8'h02;
      if (a == 12'h000 && $urandom_range(0, 3) != 0) wd[0] = 1'b1;
      k = $urandom_range(0, 9);
      w = (k < 2) || (k == 9);
      r = (k >= 2);
      op(w, r, a, wd);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule